// File: doc/BRIEF.md
# Atomic 16-bit Register Access Bridge for an 8-bit Bus

This block lets a CPU with an 8-bit data bus read and write a set of 16-bit peripheral registers without ever seeing or storing a half-updated value. The four registers are a free-running counter, two compare registers and a capture register. They live inside the block. The counter can also be advanced by hardware.

Every 16-bit register takes two byte accesses. A single 8-bit holding register sits between the bus and the high halves, and all four registers share it. A high-byte write goes only into the holding register. The matching low-byte write then commits both bytes in one clock. A low-byte read returns the live low byte and, at the same edge, copies that register's high byte into the holding register. The high-byte read that follows returns the copy.

Software must write high then low, and read low then high. If an access to another register falls between the two halves, the shared holding register is overwritten. The bridge reproduces that effect exactly and does not guard against it.

Top module: `wide_reg_bridge`

## Requirements
- R1: `bus_addr[2:1]` selects the register: 0 is the counter, 1 is compare A, 2 is compare B and 3 is capture. `bus_addr[0]` = 1 selects the high byte and 0 selects the low byte.
- R2: A high-byte write (`bus_wr` with `bus_addr[0]`=1) changes only the holding register. It raises no bit of `wr_en` and leaves all four registers unchanged.
- R3: A low-byte write raises exactly the selected bit of `wr_en` in that cycle, with `wr_bus` = {holding register, `bus_wdata`}. From the next cycle the selected register holds that value.
- R4: A low-byte read (`bus_rd` without `bus_wr`, `bus_addr[0]`=0) drives the live low byte on `bus_rdata` in the same cycle. At that clock edge it copies the selected register's live high byte into the holding register.
- R5: A high-byte read returns the holding register on `bus_rdata`, not the live high byte.
- R6: There is a single holding register for all four registers. An access to another register between the two halves overwrites it, and the later half uses the overwritten value.
- R7: When `cnt_inc` is high, the counter adds 1 per cycle and wraps from 0xFFFF to 0x0000. A low-byte write to the counter in the same cycle takes priority, so the written value is loaded with no increment.
- R8: A low-byte read followed by a high-byte read of the counter assembles the value the counter held in the low-read cycle, even if increments occur between the two reads.
- R9: `bus_rdata` is 0 when `bus_rd` is low. When `bus_rd` and `bus_wr` are both high, only the write takes effect and `bus_rdata` is 0.
- R10: After reset, all four registers and the holding register are 0 and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | 3 | Register select [2:1] and byte select [0] |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| cnt_inc | input | 1 | Hardware increment request for the counter |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| wr_bus | output | 16 | Assembled 16-bit write value |
| wr_en | output | 4 | One-hot commit enable per register |

## Verification
The bench targets the following corner cases and the failure each one would reveal:

- Increments between the two halves of a counter read. A bridge that returned the live high byte would report 0x13FF where 0x12FF is expected.
- The counter wrapping from 0xFFFF to 0x0000. A wrong wrap would show up in the read-back value.
- A counter write in the same cycle as an increment. A bridge that let the increment win would leave the counter one higher than written.
- Interleaved accesses that corrupt the holding register. These check that the corruption is reproduced exactly: a bridge with a holding register per target, or one that committed on the high write, would give a different value than expected.
- A high-byte write with no low-byte write after it, and a read and a write strobed together. These check that nothing leaks into a register or onto the read data.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int DATA_W   = 8;
  localparam int REG_W    = 2 * DATA_W;
  localparam int NUM_REGS = 4;
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int ADDR_W   = SEL_W + 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_COUNT = 2'd0,
    SEL_CMPA  = 2'd1,
    SEL_CMPB  = 2'd2,
    SEL_CAPT  = 2'd3
  } reg_sel_e;

  // register index lives above the byte-select bit
  function automatic logic [SEL_W-1:0] addr_sel(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:1];
  endfunction

  function automatic logic addr_is_high(input logic [ADDR_W-1:0] a);
    return a[0];
  endfunction

  function automatic logic [REG_W-1:0] join_word(input logic [DATA_W-1:0] hi,
                                                 input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [DATA_W-1:0] upper_of(input logic [REG_W-1:0] w);
    return w[REG_W-1:DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] lower_of(input logic [REG_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  // counter step, wraps at the all-ones value
  function automatic logic [REG_W-1:0] bump(input logic [REG_W-1:0] w);
    return w + {{(REG_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
  import wrb_pkg::*;
#(
  parameter int NREGS = NUM_REGS,
  parameter int AW    = ADDR_W,
  localparam int SW   = AW - 1
) (
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic             rd,
  output logic [SW-1:0]    sel,
  output logic             hi_wr_evt,
  output logic             lo_wr_evt,
  output logic             hi_rd_evt,
  output logic             lo_rd_evt,
  output logic [NREGS-1:0] wr_en
);
  logic high;
  logic rd_only;

  always_comb begin
    sel     = addr_sel(addr);
    high    = addr_is_high(addr);
    rd_only = rd && !wr;  // a write strobe masks a read in the same cycle
  end

  assign hi_wr_evt = wr && high;
  assign lo_wr_evt = wr && !high;
  assign hi_rd_evt = rd_only && high;
  assign lo_rd_evt = rd_only && !high;

  for (genvar g = 0; g < NREGS; g++) begin : g_en
    assign wr_en[g] = lo_wr_evt && (sel == SW'(g));
  end
endmodule

// File: rtl/wrb_temp.sv
module wrb_temp
  import wrb_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hi_wr_evt,
  input  logic          lo_rd_evt,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] snap_hi,
  output logic [DW-1:0] temp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
    end else if (hi_wr_evt) begin
      temp_q <= wdata;
    end else if (lo_rd_evt) begin
      temp_q <= snap_hi;
    end
  end
endmodule

// File: rtl/wrb_regs.sv
module wrb_regs
  import wrb_pkg::*;
#(
  parameter int NREGS = NUM_REGS,
  parameter int RW    = REG_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREGS-1:0]          wr_en,
  input  logic [RW-1:0]             wr_bus,
  input  logic                      cnt_inc,
  output logic [NREGS-1:0][RW-1:0]  reg_q
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == int'(SEL_COUNT)) begin : g_counter
      // CPU commit has priority over the hardware step
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          reg_q[g] <= '0;
        end else if (wr_en[g]) begin
          reg_q[g] <= wr_bus;
        end else if (cnt_inc) begin
          reg_q[g] <= bump(reg_q[g]);
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          reg_q[g] <= '0;
        end else if (wr_en[g]) begin
          reg_q[g] <= wr_bus;
        end
      end
    end
  end
endmodule

// File: rtl/wrb_rdmux.sv
module wrb_rdmux
  import wrb_pkg::*;
#(
  parameter int NREGS = NUM_REGS,
  parameter int DW    = DATA_W,
  localparam int RW   = 2 * DW,
  localparam int SW   = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][RW-1:0] reg_q,
  input  logic [SW-1:0]            sel,
  input  logic [DW-1:0]            temp_q,
  input  logic                     hi_rd_evt,
  input  logic                     lo_rd_evt,
  output logic [DW-1:0]            rdata,
  output logic [DW-1:0]            sel_hi
);
  logic [RW-1:0] sel_word;

  always_comb begin
    sel_word = reg_q[sel];
    sel_hi   = upper_of(sel_word);
    if (lo_rd_evt) begin
      rdata = lower_of(sel_word);
    end else if (hi_rd_evt) begin
      rdata = temp_q;
    end else begin
      rdata = '0;
    end
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int NREGS = NUM_REGS,
  localparam int RW   = 2 * DW,
  localparam int SW   = $clog2(NREGS),
  localparam int AW   = SW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             cnt_inc,
  output logic [DW-1:0]    bus_rdata,
  output logic [RW-1:0]    wr_bus,
  output logic [NREGS-1:0] wr_en
);
  // named internal events, also used by the checker
  logic [SW-1:0]            sel;
  logic                     hi_wr_evt;
  logic                     lo_wr_evt;
  logic                     hi_rd_evt;
  logic                     lo_rd_evt;
  logic [DW-1:0]            temp_q;
  logic [DW-1:0]            sel_hi;
  logic [NREGS-1:0][RW-1:0] reg_q;
  logic [RW-1:0]            cnt_q;

  wrb_decode #(.NREGS(NREGS), .AW(AW)) u_dec (
    .addr      (bus_addr),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .sel       (sel),
    .hi_wr_evt (hi_wr_evt),
    .lo_wr_evt (lo_wr_evt),
    .hi_rd_evt (hi_rd_evt),
    .lo_rd_evt (lo_rd_evt),
    .wr_en     (wr_en)
  );

  wrb_temp #(.DW(DW)) u_temp (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_wr_evt (hi_wr_evt),
    .lo_rd_evt (lo_rd_evt),
    .wdata     (bus_wdata),
    .snap_hi   (sel_hi),
    .temp_q    (temp_q)
  );

  assign wr_bus = join_word(temp_q, bus_wdata);

  wrb_regs #(.NREGS(NREGS), .RW(RW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_bus  (wr_bus),
    .cnt_inc (cnt_inc),
    .reg_q   (reg_q)
  );

  assign cnt_q = reg_q[SEL_COUNT];

  wrb_rdmux #(.NREGS(NREGS), .DW(DW)) u_rd (
    .reg_q     (reg_q),
    .sel       (sel),
    .temp_q    (temp_q),
    .hi_rd_evt (hi_rd_evt),
    .lo_rd_evt (lo_rd_evt),
    .rdata     (bus_rdata),
    .sel_hi    (sel_hi)
  );
endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
  parameter int DW    = 8,
  parameter int NREGS = 4,
  localparam int RW   = 2 * DW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [RW-1:0]    wr_bus,
  input logic [NREGS-1:0] wr_en,
  input logic             cnt_inc,
  input logic             hi_wr_evt,
  input logic             lo_wr_evt,
  input logic             hi_rd_evt,
  input logic             lo_rd_evt,
  input logic [DW-1:0]    temp_q,
  input logic [DW-1:0]    sel_hi,
  input logic [RW-1:0]    cnt_q
);
  // R2
  hi_write_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr_evt |=> (temp_q == $past(bus_wdata)));

  // R2
  hi_write_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr_evt |-> (wr_en == '0));

  // R3
  lo_write_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_evt |-> $onehot(wr_en));

  // R3
  commit_uses_prior_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr_evt |=> (lo_wr_evt -> (wr_bus[RW-1:DW] == $past(bus_wdata))));

  // R4
  lo_read_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd_evt |=> (temp_q == $past(sel_hi)));

  // R5
  hi_read_from_temp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd_evt |-> (bus_rdata == temp_q));

  // R6
  temp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_wr_evt && !lo_rd_evt) |=> $stable(temp_q));

  // R7
  counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && !wr_en[0]) |=> (cnt_q == RW'($past(cnt_q) + 1'b1)));

  // R7
  counter_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> (cnt_q == $past(wr_bus)));

  // R9
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || (!hi_rd_evt && !lo_rd_evt)) |-> (bus_rdata == '0));
endmodule

bind wide_reg_bridge wrb_checker #(.DW(DW), .NREGS(NREGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .wr_bus    (wr_bus),
  .wr_en     (wr_en),
  .cnt_inc   (cnt_inc),
  .hi_wr_evt (hi_wr_evt),
  .lo_wr_evt (lo_wr_evt),
  .hi_rd_evt (hi_rd_evt),
  .lo_rd_evt (lo_rd_evt),
  .temp_q    (temp_q),
  .sel_hi    (sel_hi),
  .cnt_q     (cnt_q)
);

// File: tb/tb_wide_reg_bridge.sv
`timescale 1ns/1ps
module tb_wide_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        cnt_inc = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] wr_bus;
  logic [3:0]  wr_en;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] m_reg [4];
  logic [7:0]  m_temp;
  logic [3:0]  exp_en;
  logic [15:0] exp_bus;
  string       cur_tag;

  // scoreboard queues
  logic [7:0] rq[$];
  string      tq[$];

  always #5 clk = ~clk;

  wide_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .cnt_inc(cnt_inc),
    .bus_rdata(bus_rdata), .wr_bus(wr_bus), .wr_en(wr_en)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: one bus cycle, model updated alongside
  task automatic step(input logic wr, input logic rd, input logic [2:0] addr,
                      input logic [7:0] wd, input logic inc, input string tag);
    logic [1:0] s;
    logic       hi;
    logic       cnt_written;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd; cnt_inc = inc;
    s  = addr[2:1];
    hi = addr[0];
    cur_tag = tag;
    exp_en  = '0;
    exp_bus = '0;
    if (wr && !hi) begin
      exp_en[s] = 1'b1;
      exp_bus   = {m_temp, wd};
    end
    if (rd && !wr) begin
      rq.push_back(hi ? m_temp : m_reg[s][7:0]);
      tq.push_back(tag);
    end
    cnt_written = wr && !hi && (s == 2'd0);
    if (wr) begin
      if (hi) m_temp = wd;
      else    m_reg[s] = {m_temp, wd};
    end else if (rd && !hi) begin
      m_temp = m_reg[s][15:8];
    end
    if (inc && !cnt_written) m_reg[0] = m_reg[0] + 16'd1;
  endtask

  task automatic idle(input int n, input logic inc);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 8'h00, inc, "idle");
  endtask

  task automatic wr16(input logic [1:0] r, input logic [15:0] v, input string tag);
    step(1'b1, 1'b0, {r, 1'b1}, v[15:8], 1'b0, tag);
    step(1'b1, 1'b0, {r, 1'b0}, v[7:0], 1'b0, tag);
  endtask

  task automatic rd16(input logic [1:0] r, input string tag);
    step(1'b0, 1'b1, {r, 1'b0}, 8'h00, 1'b0, tag);
    step(1'b0, 1'b1, {r, 1'b1}, 8'h00, 1'b0, tag);
  endtask

  // monitor: samples 2 ns after the drive edge, well before the next rise
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (bus_rd && !bus_wr) begin
        if (rq.size() == 0) begin
          chk(1'b0, "scoreboard underflow", 16'(bus_rdata), 16'h0);
        end else begin
          logic [7:0] e;
          string      t;
          e = rq.pop_front();
          t = tq.pop_front();
          chk(bus_rdata == e, t, 16'(bus_rdata), 16'(e));
        end
      end else if (bus_rd || bus_wr) begin
        chk(bus_rdata == 8'h00, "R9 rdata zero without sole read", 16'(bus_rdata), 16'h0);
      end
      if (bus_wr) begin
        chk(wr_en == exp_en, {cur_tag, " wr_en"}, 16'(wr_en), 16'(exp_en));
        if (exp_en != '0)
          chk(wr_bus == exp_bus, {cur_tag, " wr_bus"}, wr_bus, exp_bus);
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    m_temp = '0;
    exp_en = '0;
    exp_bus = '0;
    cur_tag = "";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(wr_en == 4'b0, "R10 wr_en after reset", 16'(wr_en), 16'h0);
    chk(bus_rdata == 8'h00, "R10 rdata after reset", 16'(bus_rdata), 16'h0);

    // R10: holding register and all registers start at 0
    step(1'b0, 1'b1, 3'b011, 8'h00, 1'b0, "R10 temp reset");
    for (int r = 0; r < 4; r++) rd16(2'(r), "R10 reg reset");

    // R1 R3 R4 R5: plain write then read back of compare A
    wr16(2'd1, 16'h1234, "R3 cmpA commit");
    rd16(2'd1, "R1 R4 R5 cmpA readback");
    wr16(2'd3, 16'hBEEF, "R3 capture commit");
    rd16(2'd3, "R1 capture readback");

    // R2: high write alone commits nothing
    step(1'b1, 1'b0, 3'b101, 8'hAB, 1'b0, "R2 hi write only");
    idle(2, 1'b0);
    rd16(2'd2, "R2 cmpB unchanged");

    // R6: interleaved high writes, A gets B's high byte
    step(1'b1, 1'b0, 3'b011, 8'h55, 1'b0, "R6 hi A");
    step(1'b1, 1'b0, 3'b101, 8'h66, 1'b0, "R6 hi B");
    step(1'b1, 1'b0, 3'b010, 8'h77, 1'b0, "R6 lo A uses shared temp");
    rd16(2'd1, "R6 cmpA corrupted value");
    rd16(2'd2, "R6 cmpB untouched");

    // R6: interleaved low reads
    step(1'b0, 1'b1, 3'b010, 8'h00, 1'b0, "R6 lo read A");
    step(1'b0, 1'b1, 3'b110, 8'h00, 1'b0, "R6 lo read capture");
    step(1'b0, 1'b1, 3'b011, 8'h00, 1'b0, "R6 hi read shows capture high");

    // R5: holding register, not live high, is returned
    step(1'b0, 1'b1, 3'b010, 8'h00, 1'b0, "R5 lo read A");
    step(1'b1, 1'b0, 3'b111, 8'h99, 1'b0, "R5 hi write capture");
    step(1'b0, 1'b1, 3'b011, 8'h00, 1'b0, "R5 hi read returns temp");

    // R7: counting and wrap
    wr16(2'd0, 16'h00FE, "R7 counter load");
    idle(3, 1'b1);
    rd16(2'd0, "R7 counter after three steps");
    wr16(2'd0, 16'hFFFF, "R7 counter load max");
    idle(1, 1'b1);
    rd16(2'd0, "R7 counter wrap");

    // R8: snapshot across increments
    wr16(2'd0, 16'h12FF, "R8 counter load");
    step(1'b0, 1'b1, 3'b000, 8'h00, 1'b1, "R8 lo read while counting");
    idle(4, 1'b1);
    step(1'b0, 1'b1, 3'b001, 8'h00, 1'b1, "R8 hi read keeps snapshot");
    rd16(2'd0, "R8 live counter");

    // R7: CPU write beats increment
    step(1'b1, 1'b0, 3'b001, 8'h40, 1'b1, "R7 hi write while counting");
    step(1'b1, 1'b0, 3'b000, 8'h00, 1'b1, "R7 lo write wins");
    rd16(2'd0, "R7 counter holds written value");

    // R9: read and write together, only write acts
    step(1'b1, 1'b0, 3'b101, 8'hC3, 1'b0, "R9 hi cmpB");
    step(1'b1, 1'b1, 3'b100, 8'h3C, 1'b0, "R9 rd+wr lo cmpB");
    rd16(2'd2, "R9 cmpB written");
    step(1'b1, 1'b1, 3'b111, 8'h11, 1'b0, "R9 rd+wr hi");
    step(1'b0, 1'b1, 3'b111, 8'h00, 1'b0, "R9 temp took write data");

    idle(2, 1'b0);
    chk(rq.size() == 0, "scoreboard drained", 16'(rq.size()), 16'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule